// File: doc/BRIEF.md
# Encoder Period Speed Meter

This block estimates shaft speed from an incremental encoder. It does not count events over a fixed time window. It measures the time between encoder count events, in cycles of the system clock. An upstream decoder delivers one single-cycle pulse for each A/B count event. The block runs two period measurements in parallel from that pulse train:

- **Short span:** the clock count between two successive events. It updates on every event and responds quickly at low speed, but it is noisy when the encoder edges are poor.
- **Long span:** the clock count across a programmable number of events. It updates less often, and its result is smoother at high speed.

Each measurement counter restarts when a result is captured, so every result covers only the clocks since the previous capture. A counter that receives no event climbs until it holds at all-ones, and that value marks standstill.

The results can be published in one of two modes. In free mode, each result appears as soon as it completes. In trigger-aligned mode, each result waits for an external strobe, such as a PWM period marker. The strobe then publishes the most recent completed value of each measurement. Converting a period to a physical speed is left to the consumer.

Top module: `spd_period_meas`

## Requirements
- R1: While reset is asserted, and on leaving reset, both value outputs read zero and both valid outputs are low.
- R2: The first count event after reset only starts the measurements. It produces no valid pulse on either output.
- R3: In free mode, every later count event pulses `n1_vld` high for one cycle. The pulse comes in the cycle after the event. `n1_val` then holds the number of clock edges from the previous event to this one (1 for back-to-back events).
- R4: In free mode, `nm_vld` pulses on every M-th event after the starting event. `nm_val` holds the clock edges spanned by those M events.
- R5: An M setting of 0 behaves exactly like an M setting of 1.
- R6: A span longer than 2^CNT_W−1 clocks reports all-ones on the affected output.
- R7: In free mode, no valid pulse appears in a cycle that follows a cycle without a count event.
- R8: With `sync_en` high, count events alone raise no valid pulse and leave the value outputs unchanged.
- R9: With `sync_en` high, a strobe pulses each valid output for one cycle, with the latest completed result of that measurement. A repeated strobe with no new result repeats the same value.
- R10: A strobe in the same cycle as an event that completes a measurement publishes the newly completed value.
- R11: A strobe that arrives before a measurement has ever completed produces no valid pulse for that measurement.
- R12: Each value output changes only in a cycle where its valid output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset. The block releases it synchronously inside. |
| cnt_evt | input | 1 | Single-cycle pulse for each encoder count event |
| m_cfg | input | M_W | Number of events per long-span measurement (0 is read as 1) |
| sync_strobe | input | 1 | External trigger pulse |
| sync_en | input | 1 | High selects trigger-aligned publishing; low selects free mode |
| n1_val | output | CNT_W | Clocks between the last two events |
| n1_vld | output | 1 | One-cycle pulse when `n1_val` is updated |
| nm_val | output | CNT_W | Clocks across the last M events |
| nm_vld | output | 1 | One-cycle pulse when `nm_val` is updated |

## Verification
A clock counter that is not cleared at a capture would show up at once. The very next result would be larger than the gap between the events the bench applied. An event counter that is off by one would shift `nm_vld` by one event, and a sweep over several M settings exposes that within M events. A wrong arming or latest-value register would raise a valid pulse on the starting event or on an early strobe. It could also publish a stale value in trigger-aligned mode, and the next strobe would show it.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned NUM_SPANS = 2;
  typedef enum logic {SPAN_SHORT = 1'b0, SPAN_LONG = 1'b1} span_e;
endpackage

// File: rtl/spd_span_timer.sv
module spd_span_timer #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned M_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             evt_i,
  input  logic [M_W-1:0]   span_i,
  output logic             done_o,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] clk_q, clk_d, clk_inc;
  logic [M_W-1:0]   ev_q, ev_d, span_eff;
  logic [M_W:0]     ev_nx;
  logic             last_evt;

  always_comb begin
    span_eff = (span_i == '0) ? M_W'(1) : span_i;
    clk_inc  = (clk_q == CNT_MAX) ? clk_q : clk_q + CNT_W'(1);
    ev_nx    = {1'b0, ev_q} + (M_W+1)'(1);
    last_evt = ev_nx >= {1'b0, span_eff};
    done_o   = evt_i && !restart_i && last_evt;
    period_o = clk_inc;
  end

  always_comb begin
    clk_d = clk_inc;
    ev_d  = ev_q;
    if (restart_i) begin
      clk_d = '0;
      ev_d  = '0;
    end else if (evt_i) begin
      if (last_evt) begin
        clk_d = '0;
        ev_d  = '0;
      end else begin
        ev_d = ev_nx[M_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      ev_q  <= '0;
    end else begin
      clk_q <= clk_d;
      ev_q  <= ev_d;
    end
  end
endmodule

// File: rtl/spd_result_hold.sv
module spd_result_hold #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sync_en_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] val_o,
  output logic             vld_o
);
  logic [CNT_W-1:0] latest_q, latest_d, out_q, out_d;
  logic             have_q, have_d, vld_q, vld_d;

  always_comb begin
    latest_d = latest_q;
    have_d   = have_q;
    out_d    = out_q;
    vld_d    = 1'b0;
    if (done_i) begin
      latest_d = period_i;
      have_d   = 1'b1;
    end
    if (!sync_en_i) begin
      if (done_i) begin
        out_d = period_i;
        vld_d = 1'b1;
      end
    end else if (strobe_i && (have_q || done_i)) begin
      out_d = done_i ? period_i : latest_q;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latest_q <= '0;
      have_q   <= 1'b0;
      out_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      latest_q <= latest_d;
      have_q   <= have_d;
      out_q    <= out_d;
      vld_q    <= vld_d;
    end
  end

  assign val_o = out_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/spd_period_meas.sv
module spd_period_meas #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned M_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_evt,
  input  logic [M_W-1:0]   m_cfg,
  input  logic             sync_strobe,
  input  logic             sync_en,
  output logic [CNT_W-1:0] n1_val,
  output logic             n1_vld,
  output logic [CNT_W-1:0] nm_val,
  output logic             nm_vld
);
  import spd_pkg::*;

  logic       rst_meta_q, rst_sync_n;
  logic       armed_q, armed_d, restart;

  logic             span_done [NUM_SPANS];
  logic [CNT_W-1:0] span_per  [NUM_SPANS];
  logic [CNT_W-1:0] span_val  [NUM_SPANS];
  logic             span_vld  [NUM_SPANS];
  logic [M_W-1:0]   span_len  [NUM_SPANS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    restart = cnt_evt && !armed_q;
    armed_d = armed_q || cnt_evt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= armed_d;
  end

  for (genvar g = 0; g < NUM_SPANS; g++) begin : g_span
    if (g == int'(SPAN_SHORT)) begin : g_short
      assign span_len[g] = M_W'(1);
    end else begin : g_long
      assign span_len[g] = m_cfg;
    end

    spd_span_timer #(.CNT_W(CNT_W), .M_W(M_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .restart_i (restart),
      .evt_i     (cnt_evt),
      .span_i    (span_len[g]),
      .done_o    (span_done[g]),
      .period_o  (span_per[g])
    );

    spd_result_hold #(.CNT_W(CNT_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .done_i    (span_done[g]),
      .period_i  (span_per[g]),
      .sync_en_i (sync_en),
      .strobe_i  (sync_strobe),
      .val_o     (span_val[g]),
      .vld_o     (span_vld[g])
    );
  end

  assign n1_val = span_val[int'(SPAN_SHORT)];
  assign n1_vld = span_vld[int'(SPAN_SHORT)];
  assign nm_val = span_val[int'(SPAN_LONG)];
  assign nm_vld = span_vld[int'(SPAN_LONG)];
endmodule

// File: rtl/spd_period_meas_chk.sv
module spd_period_meas_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned M_W   = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             armed_q,
  input logic             cnt_evt,
  input logic [M_W-1:0]   m_cfg,
  input logic             sync_strobe,
  input logic             sync_en,
  input logic [CNT_W-1:0] n1_val,
  input logic             n1_vld,
  input logic [CNT_W-1:0] nm_val,
  input logic             nm_vld
);
  assert_arm_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_evt && !armed_q) |=> (!n1_vld && !nm_vld));

  assert_short_every_evt_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sync_en && cnt_evt && armed_q) |=> n1_vld);

  assert_long_unit_span_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sync_en && cnt_evt && armed_q && (m_cfg <= M_W'(1))) |=> nm_vld);

  assert_nonzero_period_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    n1_vld |-> (n1_val != '0));

  assert_free_idle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sync_en && !cnt_evt) |=> (!n1_vld && !nm_vld));

  assert_sync_gated_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sync_en && !sync_strobe) |=> (!n1_vld && !nm_vld));

  assert_hold_short_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !n1_vld |-> $stable(n1_val));

  assert_hold_long_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !nm_vld |-> $stable(nm_val));
endmodule

bind spd_period_meas spd_period_meas_chk #(.CNT_W(CNT_W), .M_W(M_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .armed_q     (armed_q),
  .cnt_evt     (cnt_evt),
  .m_cfg       (m_cfg),
  .sync_strobe (sync_strobe),
  .sync_en     (sync_en),
  .n1_val      (n1_val),
  .n1_vld      (n1_vld),
  .nm_val      (nm_val),
  .nm_vld      (nm_vld)
);

// File: tb/sim_spd_period_meas.sv
module sim_spd_period_meas;
  localparam int CW   = 12;
  localparam int MW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_evt = 1'b0;
  logic [MW-1:0] m_cfg = '0;
  logic          sync_strobe = 1'b0;
  logic          sync_en = 1'b0;
  logic [CW-1:0] n1_val, nm_val;
  logic          n1_vld, nm_vld;

  int errors = 0, checks = 0;
  int armed, acc, evn, meff, pend;
  int lat1, latm, have1, havem, cur1, curm;

  always #10 clk = ~clk;

  spd_period_meas #(.CNT_W(CW), .M_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_evt(cnt_evt), .m_cfg(m_cfg),
    .sync_strobe(sync_strobe), .sync_en(sync_en),
    .n1_val(n1_val), .n1_vld(n1_vld), .nm_val(nm_val), .nm_vld(nm_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outs(input string t1, input string tm,
                            input int v1, input int vm);
    check({t1, " n1_vld"}, int'(n1_vld), v1);
    check({t1, " n1_val"}, int'(n1_val), cur1);
    check({tm, " nm_vld"}, int'(nm_vld), vm);
    check({tm, " nm_val"}, int'(nm_val), curm);
  endtask

  task automatic do_reset(input int m, input logic se);
    rst_n = 1'b0; cnt_evt = 1'b0; sync_strobe = 1'b0;
    m_cfg = MW'(m); sync_en = se;
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(n1_vld) + int'(nm_vld) + int'(n1_val) + int'(nm_val), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 0; acc = 0; evn = 0; pend = 0;
    meff = (m == 0) ? 1 : m;
    lat1 = 0; latm = 0; have1 = 0; havem = 0; cur1 = 0; curm = 0;
    check("R1 after release", int'(n1_vld) + int'(nm_vld) + int'(n1_val) + int'(nm_val), 0);
  endtask

  task automatic do_event(input int g, input logic stb);
    int gap, n1, nmv, v1, vm, e1, em, was;
    string t1, tm;
    for (int i = 0; i < g - 1; i++) begin
      @(posedge clk); @(negedge clk);
      check(sync_en ? "R8" : "R7", int'(n1_vld) + int'(nm_vld), 0);
      check("R12", int'(n1_val) * 4096 + int'(nm_val), cur1 * 4096 + curm);
    end
    cnt_evt = 1'b1; sync_strobe = stb;
    @(posedge clk); @(negedge clk);
    cnt_evt = 1'b0; sync_strobe = 1'b0;
    gap = g + pend; pend = 0;
    was = armed; v1 = 0; vm = 0; n1 = 0; nmv = 0;
    if (!armed) begin
      armed = 1; acc = 0; evn = 0;
    end else begin
      n1 = (gap > CMAX) ? CMAX : gap; v1 = 1;
      acc = (acc + gap > CMAX) ? CMAX : acc + gap;
      evn++;
      if (evn >= meff) begin vm = 1; nmv = acc; acc = 0; evn = 0; end
    end
    if (v1) begin lat1 = n1; have1 = 1; end
    if (vm) begin latm = nmv; havem = 1; end
    if (!sync_en) begin
      e1 = v1; em = vm;
      if (v1) cur1 = n1;
      if (vm) curm = nmv;
    end else begin
      e1 = (stb && have1) ? 1 : 0; em = (stb && havem) ? 1 : 0;
      if (e1 != 0) cur1 = lat1;
      if (em != 0) curm = latm;
    end
    if (was == 0) begin t1 = "R2"; tm = "R2"; end
    else if (sync_en) begin
      t1 = stb ? "R10" : "R8"; tm = stb ? "R10" : "R8";
    end else begin
      t1 = (n1 == CMAX) ? "R6" : "R3";
      tm = (m_cfg == 0) ? "R5" : ((vm != 0 && nmv == CMAX) ? "R6" : "R4");
    end
    check_outs(t1, tm, e1, em);
  endtask

  task automatic do_strobe();
    sync_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    sync_strobe = 1'b0;
    pend++;
    if (have1 != 0) cur1 = lat1;
    if (havem != 0) curm = latm;
    check_outs((have1 != 0) ? "R9" : "R11", (havem != 0) ? "R9" : "R11", have1, havem);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ms[6] = '{0, 1, 2, 3, 4, 5};
    @(negedge clk);
    // R3 R4 R5 R7 free mode sweep over M and gap patterns
    foreach (ms[k]) begin
      do_reset(ms[k], 1'b0);
      do_event(3, 1'b0);
      for (int g = 1; g <= 7; g++) do_event(g, 1'b0);
      for (int g = 7; g >= 1; g--) do_event(g, 1'b0);
      do_event(1, 1'b0); do_event(1, 1'b0); do_event(13, 1'b0);
    end
    // R6 saturation
    do_reset(2, 1'b0);
    do_event(2, 1'b0);
    do_event(5000, 1'b0);
    do_event(10, 1'b0);
    do_event(4100, 1'b0);
    do_event(4095, 1'b0);
    do_event(4094, 1'b0);
    // R8 R9 R10 R11 trigger-aligned mode
    do_reset(2, 1'b1);
    do_strobe();
    do_event(3, 1'b0);
    do_strobe();
    do_event(4, 1'b0);
    do_strobe();
    do_strobe();
    do_event(3, 1'b1);
    do_event(5, 1'b0);
    do_event(2, 1'b0);
    do_strobe();
    do_event(6, 1'b1);
    do_event(1, 1'b1);
    do_strobe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule